// File: doc/BRIEF.md
# SDRAM Controller with Static-RAM Style Port

This block sits between user logic and one single-data-rate SDRAM device with a 16-bit data bus. The user side looks like a simple static RAM. It has an address, write data, read strobe, write strobe, a busy output, and read data qualified by a one-cycle valid pulse. The read data needs a valid pulse because the memory's CAS latency delays it by several cycles. Banks, rows, refresh and latency stay hidden behind that handshake.

After reset the controller holds the device idle for the power-up interval. It then runs the start-up commands: precharge of all banks, two refreshes, and a mode register load. From then on it serves one access at a time with a close-page policy. Each access opens the row with ACTIVE and then issues one READ or WRITE with auto-precharge. Refresh is scheduled on its own and takes priority over a waiting request.

All timing limits are given as nanosecond parameters and rounded up to clock cycles at 100 MHz. The memory geometry (rows, columns, banks) is set by parameters, so a 4096 x 256 part needs only new parameter values.

The state machine has these states and transitions:
- ST_POWERUP waits, issues PRECHARGE-all and moves to ST_INIT_RF1.
- ST_INIT_RF1 issues REFRESH and moves to ST_INIT_RF2.
- ST_INIT_RF2 issues REFRESH and moves to ST_INIT_MODE.
- ST_INIT_MODE issues LOAD MODE and moves to ST_IDLE.
- ST_IDLE issues either a REFRESH and stays in ST_IDLE, or an ACTIVE and moves to ST_ACCESS.
- ST_ACCESS issues READ or WRITE and returns to ST_IDLE.

Every state holds off its next command until a shared gap counter expires.

Top module: `sdram_sram_bridge`

## Requirements
- R1: While reset is low and for at least 20000 cycles after it is released, busy is 1 and the command is NOP. The command pins {cs_n,ras_n,cas_n,we_n} = 0111 during that time.
- R2: The first commands are, in order: PRECHARGE with A10=1, REFRESH, REFRESH, and LOAD MODE with bank 0 and A=0x020 (CAS latency 2, burst length 1, sequential). The spacing is at least 2 cycles from PRECHARGE to the first REFRESH, at least 7 cycles after each REFRESH, and at least 2 cycles from LOAD MODE to the next command. Busy stays 1 until the sequence is done.
- R3: Command encodings {cs_n,ras_n,cas_n,we_n} are: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, LOAD MODE 0000. Every cycle without a command carries NOP.
- R4: The user address splits from high bits to low as bank (2 bits), row (13 bits) and column (9 bits). ACTIVE drives the bank on sd_ba and the row on sd_a. READ and WRITE drive the same bank and put the column on sd_a[8:0] with sd_a[10]=1 (auto-precharge).
- R5: A READ or WRITE comes at least 2 cycles after its ACTIVE (15 ns rounded up).
- R6: Consecutive ACTIVE or REFRESH commands that follow an ACTIVE come at least 7 cycles after it (45 ns + 15 ns). No explicit PRECHARGE is issued after start-up.
- R7: Once started, consecutive REFRESH commands are at most 781 cycles apart (64 ms / 8192 rows at 100 MHz), even while requests are held without a break. No command follows a REFRESH within 7 cycles (66 ns rounded up).
- R8: A READ issued in cycle k makes rd_valid high for exactly cycle k+3. rd_data then carries the word the device returned, so a read returns the last data written to that address.
- R9: In a WRITE cycle sd_dq_oe=1, sd_dq_out carries the accepted write data and sd_dqm=0. In every other cycle sd_dq_oe=0.
- R10: A strobe is taken only in a cycle where busy is 0, and that request's ACTIVE appears in the next cycle. A strobe while busy is 1 has no effect on commands or memory contents. When both strobes are high, the write is taken.
- R11: sd_clk is the inverse of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | 24 | Word address {bank,row,column} |
| req_wdata | input | 16 | Write data |
| req_rd | input | 1 | Read strobe, held until busy is low |
| req_wr | input | 1 | Write strobe, held until busy is low |
| busy | output | 1 | Request cannot be taken this cycle |
| rd_data | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle read data qualifier |
| sd_clk | output | 1 | Memory clock, inverted clk |
| sd_cke | output | 1 | Clock enable, high after reset |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Row/column address, A10 auto-precharge |
| sd_dqm | output | 2 | Byte masks, held 0 |
| sd_dq_out | output | 16 | Data toward the device |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data from the device |

## Verification
The assertions check the following on every cycle:
- the row-to-column gap, the active-to-active gap and the post-refresh quiet time;
- the 781-cycle refresh ceiling;
- the auto-precharge bit;
- that each ACTIVE follows a cycle where a strobe met a low busy;
- the exact read-valid latency and that rd_valid lasts one cycle.

Some behaviour only the bench scenarios can show:
- that data written at one address returns unchanged after other banks, rows and columns were touched;
- that a strobe dropped during busy leaves memory contents intact;
- that the start-up order and mode word are right;
- that refresh keeps its deadline under back-to-back requests.

// File: rtl/sdr_pkg.sv
`timescale 1ns/1ps
package sdr_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_INIT_RF1,
        ST_INIT_RF2,
        ST_INIT_MODE,
        ST_IDLE,
        ST_ACCESS
    } sdr_state_e;

    // nanoseconds to clock cycles, rounded up
    function automatic int ns_to_cyc(input int ns, input int clk_mhz);
        return (ns * clk_mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
`timescale 1ns/1ps
module sdr_refresh_timer #(
    parameter int LOAD = 772
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(LOAD + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(LOAD - 1);
            due <= 1'b0;
        end else if (ack) begin
            cnt <= CW'(LOAD - 1);
            due <= 1'b0;
        end else if (cnt == '0) begin
            due <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R7: a pending refresh is never dropped without being served
    p_due_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !ack) |=> due);

endmodule

// File: rtl/sdr_read_capture.sv
`timescale 1ns/1ps
module sdr_read_capture #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [CAS_LAT-1:0] pipe;

    generate
        if (CAS_LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= issue;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[CAS_LAT-2:0], issue};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= pipe[CAS_LAT-1];
            if (pipe[CAS_LAT-1]) rd_data <= dq_in;
        end
    end

    // R8: valid lands exactly CAS latency + 1 cycles after the READ cycle
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(issue, CAS_LAT + 1));
    // R8: one pulse per read
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdram_sram_bridge.sv
`timescale 1ns/1ps
module sdram_sram_bridge
    import sdr_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int ROWS         = 8192,
    parameter int COLS         = 512,
    parameter int BANKS        = 4,
    parameter int DATA_W       = 16,
    parameter int CAS_LAT      = 2,
    parameter int T_POWERUP_NS = 200000,
    parameter int T_RCD_NS     = 15,
    parameter int T_RP_NS      = 15,
    parameter int T_RAS_NS     = 45,
    parameter int T_RFC_NS     = 66,
    parameter int T_WR_NS      = 15,
    parameter int T_REFWIN_US  = 64000,
    parameter int MRD_CYC      = 2,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int BA_W   = $clog2(BANKS),
    localparam int ADDR_W = BA_W + ROW_W + COL_W,
    localparam int A_W    = (ROW_W > 11) ? ROW_W : 11,
    localparam int DQM_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_rd,
    input  logic              req_wr,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sd_clk,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [A_W-1:0]    sd_a,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    localparam int INIT_C  = ns_to_cyc(T_POWERUP_NS, CLK_MHZ);
    localparam int RCD_C   = ns_to_cyc(T_RCD_NS, CLK_MHZ);
    localparam int RP_C    = ns_to_cyc(T_RP_NS, CLK_MHZ);
    localparam int RAS_C   = ns_to_cyc(T_RAS_NS, CLK_MHZ);
    localparam int RFC_C   = ns_to_cyc(T_RFC_NS, CLK_MHZ);
    localparam int WR_C    = ns_to_cyc(T_WR_NS, CLK_MHZ);
    localparam int RC_C    = RAS_C + RP_C;
    localparam int POST_RW = ((RC_C - RCD_C) > (WR_C + RP_C)) ? (RC_C - RCD_C) : (WR_C + RP_C);
    localparam int REF_WIN_C = (T_REFWIN_US * CLK_MHZ) / ROWS;
    // worst case: an access starts just before the timer fires
    localparam int REF_LOAD  = REF_WIN_C - (POST_RW + RCD_C) - 2;
    localparam int GAP_W     = $clog2(INIT_C + 1);
    localparam logic [A_W-1:0] MODE_WORD = A_W'(CAS_LAT << 4);

    sdr_state_e        st, st_n;
    logic [GAP_W-1:0]  gap, gap_n;
    sdr_cmd_e          cmd_q, cmd_n;
    logic [BA_W-1:0]   ba_q, ba_n;
    logic [A_W-1:0]    a_q, a_n;
    logic [DATA_W-1:0] dout_q, dout_n;
    logic              oe_q, oe_n;
    logic              cke_q;
    logic              ref_due, ref_ack, take;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              lat_wr;

    assign busy = !((st == ST_IDLE) && (gap == '0) && !ref_due);

    sdr_refresh_timer #(.LOAD(REF_LOAD)) i_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .due   (ref_due)
    );

    sdr_read_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (cmd_q == CMD_RD),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // next state and next command
    always_comb begin
        st_n    = st;
        gap_n   = (gap != '0) ? gap - 1'b1 : '0;
        cmd_n   = CMD_NOP;
        ba_n    = '0;
        a_n     = '0;
        oe_n    = 1'b0;
        dout_n  = dout_q;
        ref_ack = 1'b0;
        take    = 1'b0;
        unique case (st)
            ST_POWERUP: if (gap == '0) begin
                cmd_n     = CMD_PRE;
                a_n[10]   = 1'b1;
                st_n      = ST_INIT_RF1;
                gap_n     = GAP_W'(RP_C - 1);
            end
            ST_INIT_RF1: if (gap == '0) begin
                cmd_n     = CMD_REF;
                ref_ack   = 1'b1;
                st_n      = ST_INIT_RF2;
                gap_n     = GAP_W'(RFC_C - 1);
            end
            ST_INIT_RF2: if (gap == '0) begin
                cmd_n     = CMD_REF;
                ref_ack   = 1'b1;
                st_n      = ST_INIT_MODE;
                gap_n     = GAP_W'(RFC_C - 1);
            end
            ST_INIT_MODE: if (gap == '0) begin
                cmd_n     = CMD_LMR;
                a_n       = MODE_WORD;
                st_n      = ST_IDLE;
                gap_n     = GAP_W'(MRD_CYC - 1);
            end
            ST_IDLE: if (gap == '0) begin
                if (ref_due) begin
                    cmd_n   = CMD_REF;
                    ref_ack = 1'b1;
                    gap_n   = GAP_W'(RFC_C - 1);
                end else if (req_rd || req_wr) begin
                    take    = 1'b1;
                    cmd_n   = CMD_ACT;
                    ba_n    = req_addr[ADDR_W-1 -: BA_W];
                    a_n     = A_W'(req_addr[COL_W +: ROW_W]);
                    st_n    = ST_ACCESS;
                    gap_n   = GAP_W'(RCD_C - 1);
                end
            end
            ST_ACCESS: if (gap == '0) begin
                cmd_n     = lat_wr ? CMD_WR : CMD_RD;
                ba_n      = lat_addr[ADDR_W-1 -: BA_W];
                a_n       = A_W'(lat_addr[COL_W-1:0]);
                a_n[10]   = 1'b1;
                oe_n      = lat_wr;
                dout_n    = lat_data;
                st_n      = ST_IDLE;
                gap_n     = GAP_W'(POST_RW - 1);
            end
            default: st_n = ST_POWERUP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_POWERUP;
            gap <= GAP_W'(INIT_C - 1);
        end else begin
            st  <= st_n;
            gap <= gap_n;
        end
    end

    // registered outputs and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= CMD_NOP;
            ba_q     <= '0;
            a_q      <= '0;
            oe_q     <= 1'b0;
            dout_q   <= '0;
            cke_q    <= 1'b0;
            lat_addr <= '0;
            lat_data <= '0;
            lat_wr   <= 1'b0;
        end else begin
            cmd_q  <= cmd_n;
            ba_q   <= ba_n;
            a_q    <= a_n;
            oe_q   <= oe_n;
            dout_q <= dout_n;
            cke_q  <= 1'b1;
            if (take) begin
                lat_addr <= req_addr;
                lat_data <= req_wdata;
                lat_wr   <= req_wr;
            end
        end
    end

    assign sd_clk    = ~clk;
    assign sd_cke    = cke_q;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba     = ba_q;
    assign sd_a      = a_q;
    assign sd_dqm    = '0;
    assign sd_dq_out = dout_q;
    assign sd_dq_oe  = oe_q;

    // checker counters: cycles since last ACTIVE / REFRESH seen on the pins
    logic [15:0] since_act, since_ref;
    logic        init_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= 16'hFFFF;
            since_ref <= 16'hFFFF;
            init_done <= 1'b0;
        end else begin
            if (cmd_q == CMD_ACT)          since_act <= 16'd1;
            else if (since_act != 16'hFFFF) since_act <= since_act + 16'd1;
            if (cmd_q == CMD_REF)          since_ref <= 16'd1;
            else if (since_ref != 16'hFFFF) since_ref <= since_ref + 16'd1;
            if (cmd_q == CMD_LMR)          init_done <= 1'b1;
        end
    end

    // R5: row-to-column delay
    p_trcd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> since_act >= 16'(RCD_C));
    // R6: row cycle before the next ACTIVE or REFRESH
    p_trc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> since_act >= 16'(RC_C));
    // R7: quiet time after a refresh
    p_trfc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NOP) |-> since_ref >= 16'(RFC_C));
    // R7: refresh deadline
    p_refresh_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> since_ref <= 16'(REF_WIN_C));
    // R4: column commands always close the row
    p_autoprecharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_a[10]);
    // R10: an ACTIVE only follows a strobe seen with busy low
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |-> $past(!busy && (req_rd || req_wr)));

endmodule

// File: tb/test_sdram_sram_bridge.sv
`timescale 1ns/1ps
module test_sdram_sram_bridge;

    localparam int INIT_C  = 20000;
    localparam int RCD_C   = 2;
    localparam int RP_C    = 2;
    localparam int RC_C    = 7;
    localparam int RFC_C   = 7;
    localparam int MRD_C   = 2;
    localparam int REF_MAX = 781;
    localparam int CL      = 2;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic        busy, rd_valid, sd_clk, sd_cke;
    logic [15:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_a;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = '0;

    always #2.5 clk = ~clk;

    sdram_sram_bridge i_sdram_sram_bridge (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rd(req_rd), .req_wr(req_wr), .busy(busy), .rd_data(rd_data),
        .rd_valid(rd_valid), .sd_clk(sd_clk), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // behavioural model state
    logic [15:0] exp_mem [int];
    logic [15:0] dev_mem [int];
    logic [12:0] open_row [4];
    logic [15:0] dq_pipe [4];
    int          exp_cyc [$];
    logic [15:0] exp_dat [$];
    int  cyc = 0, init_step = 0, last_act = -1000, last_ref = -1000, last_lmr = -1000;
    bit  seen_run_ref = 0;
    bit  prev_acc = 0;
    logic [23:0] pend_addr = '0;
    logic [15:0] pend_data = '0;

    // monitor, reference model and device model, all at mid-cycle
    always @(negedge clk) begin
        logic [3:0] cmd;
        logic [15:0] rv;
        int key;
        if (rst_n) begin
            cyc++;
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (sd_clk !== 1'b1) chk(0, "R11 sd_clk", sd_clk, 1);
            if (init_step < 4 && !busy) chk(0, "R2 busy during start-up", busy, 1);
            // acceptance (R10)
            if (prev_acc || cmd == C_ACT)
                chk(prev_acc && cmd == C_ACT, "R10 accept->ACTIVE", cmd, C_ACT);
            // device output pipeline
            sd_dq_in = dq_pipe[0];
            for (int i = 0; i < 3; i++) dq_pipe[i] = dq_pipe[i+1];
            dq_pipe[3] = 16'h0;
            if (cmd != C_NOP)
                chk(cmd inside {C_ACT, C_RD, C_WR, C_PRE, C_REF, C_LMR}, "R3 legal command", cmd, C_NOP);
            case (cmd)
                C_PRE: begin
                    chk(init_step == 0 && sd_a[10] && cyc >= INIT_C, "R1 PRECHARGE first, after wait", cyc, INIT_C);
                    init_step = 1;
                    last_ref = cyc - 100 + RP_C;  // used below for PRE->REF gap
                end
                C_REF: begin
                    if (init_step == 1) begin
                        chk(cyc - (last_ref + 100 - RP_C) >= RP_C, "R2 PRECHARGE->REFRESH gap", cyc, RP_C);
                        init_step = 2;
                    end else if (init_step == 2) begin
                        chk(cyc - last_ref >= RFC_C, "R2 REFRESH->REFRESH gap", cyc - last_ref, RFC_C);
                        init_step = 3;
                    end else begin
                        chk(init_step == 4, "R2 refresh only after mode load", init_step, 4);
                        chk(cyc - last_ref <= REF_MAX, "R7 refresh interval", cyc - last_ref, REF_MAX);
                        chk(cyc - last_ref >= RFC_C, "R7 refresh spacing", cyc - last_ref, RFC_C);
                        chk(cyc - last_act >= RC_C, "R6 ACTIVE->REFRESH gap", cyc - last_act, RC_C);
                        seen_run_ref = 1;
                    end
                    last_ref = cyc;
                end
                C_LMR: begin
                    chk(init_step == 3, "R2 mode load order", init_step, 3);
                    chk(sd_a == 13'h020 && sd_ba == 2'd0, "R2 mode word", sd_a, 13'h020);
                    chk(cyc - last_ref >= RFC_C, "R2 REFRESH->LOAD MODE gap", cyc - last_ref, RFC_C);
                    init_step = 4;
                    last_lmr = cyc;
                end
                C_ACT: begin
                    chk(init_step == 4 && cyc - last_lmr >= MRD_C, "R2 mode->first command", cyc - last_lmr, MRD_C);
                    chk(cyc - last_act >= RC_C, "R6 ACTIVE->ACTIVE gap", cyc - last_act, RC_C);
                    chk(cyc - last_ref >= RFC_C, "R7 REFRESH->ACTIVE gap", cyc - last_ref, RFC_C);
                    chk(sd_ba == pend_addr[23:22] && sd_a == pend_addr[21:9], "R4 bank/row split",
                        {sd_ba, sd_a}, pend_addr[23:9]);
                    open_row[sd_ba] = sd_a;
                    last_act = cyc;
                end
                C_RD, C_WR: begin
                    chk(cyc - last_act >= RCD_C, "R5 ACTIVE->column gap", cyc - last_act, RCD_C);
                    chk(sd_a[10] && sd_a[8:0] == pend_addr[8:0] && sd_ba == pend_addr[23:22],
                        "R4 column and auto-precharge", sd_a, {4'b0010, pend_addr[8:0]});
                    key = {sd_ba, open_row[sd_ba], sd_a[8:0]};
                    if (cmd == C_WR) begin
                        chk(sd_dq_oe && sd_dq_out == pend_data && sd_dqm == 2'b00, "R9 write drive",
                            sd_dq_out, pend_data);
                        dev_mem[key] = sd_dq_out;
                    end else begin
                        rv = dev_mem.exists(key) ? dev_mem[key] : 16'hDEAD;
                        dq_pipe[CL-1] = rv;
                        exp_cyc.push_back(cyc + CL + 1);
                        exp_dat.push_back(exp_mem.exists(int'(pend_addr)) ? exp_mem[int'(pend_addr)] : 16'hDEAD);
                    end
                end
                default: ;
            endcase
            if (cmd != C_WR && sd_dq_oe) chk(0, "R9 bus driven outside write", sd_dq_oe, 0);
            // read return (R8)
            if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
                chk(rd_valid === 1'b1 && rd_data == exp_dat[0], "R8 read data/latency",
                    {rd_valid, rd_data}, {1'b1, exp_dat[0]});
                void'(exp_cyc.pop_front());
                void'(exp_dat.pop_front());
            end else if (rd_valid) begin
                chk(0, "R8 unexpected rd_valid", rd_valid, 0);
            end
            // acceptance this cycle
            prev_acc = !busy && (req_rd || req_wr);
            if (prev_acc) begin
                pend_addr = req_addr;
                pend_data = req_wdata;
                if (req_wr) exp_mem[int'(req_addr)] = req_wdata;
            end
        end
    end

    task automatic access(input bit w, input logic [23:0] addr, input logic [15:0] d);
        @(posedge clk); #1;
        req_addr = addr; req_wdata = d; req_wr = w; req_rd = !w;
        do @(negedge clk); while (busy);
        @(posedge clk); #1;
        req_wr = 0; req_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) dq_pipe[i] = '0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b1 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !rd_valid && !sd_dq_oe,
            "R1 reset state", {busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {1'b1, C_NOP});
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        while (busy) @(negedge clk);
        chk(init_step == 4 && cyc >= INIT_C, "R1 start-up complete before busy drops", cyc, INIT_C);

        // basic and corner addresses
        access(1, 24'h000000, 16'h1234);
        access(0, 24'h000000, 16'h0);
        access(1, 24'hFFFFFF, 16'hBEEF);
        access(1, {2'd1, 13'h1555, 9'h0AA}, 16'hA5C3);
        access(1, {2'd1, 13'h1555, 9'h0AB}, 16'h0F0F);
        access(0, 24'hFFFFFF, 16'h0);
        access(0, {2'd1, 13'h1555, 9'h0AA}, 16'h0);
        access(0, {2'd1, 13'h1555, 9'h0AB}, 16'h0);

        // strobes while busy are ignored (R10)
        access(1, {2'd2, 13'h0042, 9'h011}, 16'hAAAA);
        req_addr = {2'd2, 13'h0042, 9'h011}; req_wdata = 16'h5555; req_wr = 1;
        @(negedge clk);
        chk(busy === 1'b1, "R10 strobe issued while busy", busy, 1);
        @(posedge clk); #1 req_wr = 0; req_rd = 1;
        @(negedge clk);
        chk(busy === 1'b1, "R10 strobe issued while busy", busy, 1);
        @(posedge clk); #1 req_rd = 0;
        access(0, {2'd2, 13'h0042, 9'h011}, 16'h0);
        idle(10);

        // back-to-back load across several refresh windows (R7 priority)
        for (int i = 0; i < 300; i++)
            access(1, 24'((i * 4099 + 7) & 24'hFFFFFF), 16'((i * 97) ^ 16'h3C5A));
        for (int i = 0; i < 300; i++)
            access(0, 24'((i * 4099 + 7) & 24'hFFFFFF), 16'h0);
        idle(2000);
        chk(seen_run_ref, "R7 refresh observed in operation", seen_run_ref, 1);
        chk(exp_cyc.size() == 0, "R8 all reads returned", exp_cyc.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule